// File: doc/BRIEF.md
# Voltage-loop PI regulator with burst-mode reference shaping

This block closes the slow voltage loop of a multi-phase boost converter. A free-running
switching-cycle strobe drives it, and the loop evaluates once for every ten strobes. On each
evaluation it forms the error between the programmed output-voltage target and the most
recently captured ADC sample. A fixed-point proportional-integral law turns that error into a
requested peak-current reference. The request then passes through a low-load shaping law and
an overvoltage guard before it reaches the DAC code and the per-phase switching enables.

The shaping law has three zones. A large request passes through, capped at a programmed
ceiling. A moderate request is raised to a programmed floor. A small request stops switching
altogether. Separately, any sample that sits above the target by more than a programmed
margin turns switching off for that evaluation. This keeps the bus bounded when the load
drops away.

The evaluation is sequenced by a four-state machine. ST_IDLE waits for the divided update
tick. ST_DIFF latches the error and the overvoltage flag. ST_ACCUM updates the integrator and
forms the rounded controller output. ST_SHAPE applies the zone law. The transitions are:
ST_IDLE→ST_DIFF on tick, ST_IDLE→ST_IDLE otherwise, ST_DIFF→ST_ACCUM, ST_ACCUM→ST_SHAPE and
ST_SHAPE→ST_IDLE. The outputs are registered on the ST_SHAPE→ST_IDLE transition.

Top module: `vloop_burst_ctrl`

## Requirements
- R1: Exactly one evaluation is made per ten `cyc_start` strobes, counted from reset. `dac_valid` is a single-cycle pulse that appears on the fourth rising edge after the edge that samples the tenth strobe.
- R2: The error is e = vset − sample, a signed 13-bit value, where sample is the last `adc_data` captured with `adc_valid`. `kp` and `ki` are signed Q8.8 values. The controller output is u = floor((kp·e + I + 128) / 256), where I is the integrator value after this evaluation's update.
- R3: The integrator is a 32-bit signed accumulator. Each evaluation adds ki·e, and the result saturates at −2^31 and 2^31−1.
- R4: When the previous evaluation's u was at or above `ref_max` and e > 0, the integrator keeps its value for this evaluation.
- R5: If the clamped value c is at least `ref_min`, the DAC code is c, where c is 0 for u < 0, `ref_max` for u ≥ `ref_max`, and u otherwise.
- R6: If `ref_min`>>1 ≤ c < `ref_min`, the DAC code is `ref_min` and the phases stay enabled.
- R7: If c < `ref_min`>>1, the DAC code is 0 and every phase enable is low. In the other zones every phase enable is high.
- R8: If sample > vset + `ov_margin`, the DAC code is 0 and every phase enable is low, whatever u is. A sample equal to vset + `ov_margin` does not trip this guard.
- R9: A synchronous `rst` clears the integrator, the stored sample, the strobe count, the DAC code, `dac_valid` and every phase enable.
- R10: Between evaluations, `dac_code` and `phase_en` hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cyc_start | input | 1 | One-cycle strobe at the start of each switching cycle |
| adc_valid | input | 1 | Qualifies `adc_data` |
| adc_data | input | 12 | Output-voltage sample, unsigned |
| vset | input | 12 | Output-voltage target, unsigned, same scale as the sample |
| kp | input | 16 | Proportional gain, signed Q8.8 |
| ki | input | 16 | Integral gain per evaluation, signed Q8.8 |
| ref_min | input | 10 | Floor of the reference in the normal zone |
| ref_max | input | 10 | Ceiling of the reference |
| ov_margin | input | 12 | Overvoltage margin above `vset` |
| dac_valid | output | 1 | Pulses when a new code is published |
| dac_code | output | 10 | Peak-current reference code |
| phase_en | output | 2 | Per-phase switching enables |

## Verification
Integrator saturation is the hardest situation to reach. A positive run-up is stopped early by the ceiling hold, so the stimulus drives the negative side. With the proportional gain at zero, it holds the largest integral gain against a full-scale negative error for twenty evaluations. It then reverses the error and checks every recovery step, because an accumulator that wrapped or kept growing past its bound would publish different codes while it climbs back. The overvoltage boundary needs a positive integrator while the sample sits above the target, so that case comes after a deliberate run-up.

// File: rtl/vloop_pkg.sv
package vloop_pkg;

    // Sequencer states of one loop evaluation
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_DIFF  = 2'd1,
        ST_ACCUM = 2'd2,
        ST_SHAPE = 2'd3
    } vl_state_e;

    // Low-load shaping zones
    typedef enum logic [1:0] {
        ZN_OFF   = 2'd0,
        ZN_FLOOR = 2'd1,
        ZN_PASS  = 2'd2
    } vl_zone_e;

    // Fractional bits of the Q8.8 gains
    localparam int FRAC_BITS = 8;

endpackage

// File: rtl/vloop_tick_div.sv
module vloop_tick_div #(
    parameter int DIV = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic strobe,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            tick  <= 1'b0;
        end else if (strobe) begin
            if (cnt_q == LAST) begin
                cnt_q <= '0;
                tick  <= 1'b1;
            end else begin
                cnt_q <= cnt_q + 1'b1;
                tick  <= 1'b0;
            end
        end else begin
            tick <= 1'b0;
        end
    end

    AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (rst)
        (tick && !strobe) |=> !tick); // R1

endmodule

// File: rtl/vloop_pi_core.sv
module vloop_pi_core
    import vloop_pkg::*;
#(
    parameter int ADC_W  = 12,
    parameter int GAIN_W = 16,
    parameter int ACC_W  = 32,
    localparam int ERR_W  = ADC_W + 1,
    localparam int PROD_W = GAIN_W + ERR_W,
    localparam int WIDE_W = ((ACC_W > PROD_W) ? ACC_W : PROD_W) + 1,
    localparam int SUM_W  = WIDE_W + 1
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    diff_ld,
    input  logic                    acc_ld,
    input  logic [ADC_W-1:0]        sample,
    input  logic [ADC_W-1:0]        vset,
    input  logic [ADC_W-1:0]        ov_margin,
    input  logic [GAIN_W-1:0]       kp,
    input  logic [GAIN_W-1:0]       ki,
    input  logic                    at_max,
    output logic                    ov_q,
    output logic signed [SUM_W-1:0] u_q
);
    localparam logic signed [ACC_W-1:0] A_MAX = {1'b0, {(ACC_W-1){1'b1}}};
    localparam logic signed [ACC_W-1:0] A_MIN = {1'b1, {(ACC_W-1){1'b0}}};
    localparam logic signed [SUM_W-1:0] RND_HALF = SUM_W'(2 ** (FRAC_BITS - 1));

    logic signed [ERR_W-1:0]  err_c, err_q;
    logic                     ov_c;
    logic [ERR_W-1:0]         ceil_c;
    logic signed [GAIN_W-1:0] kp_s, ki_s;
    logic signed [PROD_W-1:0] p_full, i_full;
    logic signed [WIDE_W-1:0] i_sum;
    logic signed [ACC_W-1:0]  integ_q, integ_sat, integ_nxt;
    logic signed [SUM_W-1:0]  sum_c, u_c;
    logic                     hold;

    // Error and overvoltage decision, latched in ST_DIFF
    assign err_c  = $signed({1'b0, vset}) - $signed({1'b0, sample});
    assign ceil_c = {1'b0, vset} + {1'b0, ov_margin};
    assign ov_c   = ({1'b0, sample} > ceil_c);

    always_ff @(posedge clk) begin
        if (rst) begin
            err_q <= '0;
            ov_q  <= 1'b0;
        end else if (diff_ld) begin
            err_q <= err_c;
            ov_q  <= ov_c;
        end
    end

    // Full-width products
    assign kp_s   = $signed(kp);
    assign ki_s   = $signed(ki);
    assign p_full = PROD_W'(kp_s) * PROD_W'(err_q);
    assign i_full = PROD_W'(ki_s) * PROD_W'(err_q);

    // Saturating integrator with conditional hold against windup
    assign i_sum = WIDE_W'(integ_q) + WIDE_W'(i_full);
    assign hold  = at_max && !err_q[ERR_W-1] && (err_q != '0);

    always_comb begin
        if (i_sum > WIDE_W'(A_MAX)) begin
            integ_sat = A_MAX;
        end else if (i_sum < WIDE_W'(A_MIN)) begin
            integ_sat = A_MIN;
        end else begin
            integ_sat = i_sum[ACC_W-1:0];
        end
        integ_nxt = hold ? integ_q : integ_sat;
    end

    // Round half up, then drop fractional bits with sign
    assign sum_c = SUM_W'(p_full) + SUM_W'(integ_nxt) + RND_HALF;
    assign u_c   = sum_c >>> FRAC_BITS;

    always_ff @(posedge clk) begin
        if (rst) begin
            integ_q <= '0;
            u_q     <= '0;
        end else if (acc_ld) begin
            integ_q <= integ_nxt;
            u_q     <= u_c;
        end
    end

    AST_INTEG_HOLD: assert property (@(posedge clk) disable iff (rst)
        (acc_ld && hold) |=> (integ_q == $past(integ_q))); // R4

    AST_INTEG_IDLE: assert property (@(posedge clk) disable iff (rst)
        !acc_ld |=> (integ_q == $past(integ_q))); // R3

endmodule

// File: rtl/vloop_burst_map.sv
module vloop_burst_map
    import vloop_pkg::*;
#(
    parameter int U_W   = 34,
    parameter int DAC_W = 10
) (
    input  logic signed [U_W-1:0] u,
    input  logic                  ov,
    input  logic [DAC_W-1:0]      ref_min,
    input  logic [DAC_W-1:0]      ref_max,
    output logic [DAC_W-1:0]      code,
    output vl_zone_e              zone,
    output logic                  at_max
);
    logic signed [U_W-1:0] max_ext;
    logic [DAC_W-1:0]      clampv;
    logic [DAC_W-1:0]      half_min;

    assign max_ext  = $signed({{(U_W-DAC_W){1'b0}}, ref_max});
    assign half_min = ref_min >> 1;

    always_comb begin
        at_max = (u >= max_ext);
        if (u[U_W-1]) begin
            clampv = '0;
        end else if (at_max) begin
            clampv = ref_max;
        end else begin
            clampv = u[DAC_W-1:0];
        end

        if (ov) begin
            zone = ZN_OFF;
            code = '0;
        end else if (clampv >= ref_min) begin
            zone = ZN_PASS;
            code = clampv;
        end else if (clampv >= half_min) begin
            zone = ZN_FLOOR;
            code = ref_min;
        end else begin
            zone = ZN_OFF;
            code = '0;
        end
    end

endmodule

// File: rtl/vloop_burst_ctrl.sv
module vloop_burst_ctrl
    import vloop_pkg::*;
#(
    parameter int ADC_W  = 12,
    parameter int DAC_W  = 10,
    parameter int GAIN_W = 16,
    parameter int ACC_W  = 32,
    parameter int DIV    = 10,
    parameter int NPH    = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cyc_start,
    input  logic              adc_valid,
    input  logic [ADC_W-1:0]  adc_data,
    input  logic [ADC_W-1:0]  vset,
    input  logic [GAIN_W-1:0] kp,
    input  logic [GAIN_W-1:0] ki,
    input  logic [DAC_W-1:0]  ref_min,
    input  logic [DAC_W-1:0]  ref_max,
    input  logic [ADC_W-1:0]  ov_margin,
    output logic              dac_valid,
    output logic [DAC_W-1:0]  dac_code,
    output logic [NPH-1:0]    phase_en
);
    localparam int ERR_W  = ADC_W + 1;
    localparam int PROD_W = GAIN_W + ERR_W;
    localparam int WIDE_W = ((ACC_W > PROD_W) ? ACC_W : PROD_W) + 1;
    localparam int SUM_W  = WIDE_W + 1;

    vl_state_e             state_q, state_d;
    logic                  tick;
    logic [ADC_W-1:0]      sample_q;
    logic                  ov_q;
    logic signed [SUM_W-1:0] u_q;
    logic [DAC_W-1:0]      map_code;
    vl_zone_e              map_zone;
    logic                  map_at_max;
    logic                  at_max_q;
    logic                  run_en;

    // Sample capture
    always_ff @(posedge clk) begin
        if (rst) begin
            sample_q <= '0;
        end else if (adc_valid) begin
            sample_q <= adc_data;
        end
    end

    vloop_tick_div #(.DIV(DIV)) u_div (
        .clk    (clk),
        .rst    (rst),
        .strobe (cyc_start),
        .tick   (tick)
    );

    vloop_pi_core #(
        .ADC_W  (ADC_W),
        .GAIN_W (GAIN_W),
        .ACC_W  (ACC_W)
    ) u_pi (
        .clk       (clk),
        .rst       (rst),
        .diff_ld   (state_q == ST_DIFF),
        .acc_ld    (state_q == ST_ACCUM),
        .sample    (sample_q),
        .vset      (vset),
        .ov_margin (ov_margin),
        .kp        (kp),
        .ki        (ki),
        .at_max    (at_max_q),
        .ov_q      (ov_q),
        .u_q       (u_q)
    );

    vloop_burst_map #(
        .U_W   (SUM_W),
        .DAC_W (DAC_W)
    ) u_map (
        .u       (u_q),
        .ov      (ov_q),
        .ref_min (ref_min),
        .ref_max (ref_max),
        .code    (map_code),
        .zone    (map_zone),
        .at_max  (map_at_max)
    );

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  state_d = tick ? ST_DIFF : ST_IDLE;
            ST_DIFF:  state_d = ST_ACCUM;
            ST_ACCUM: state_d = ST_SHAPE;
            ST_SHAPE: state_d = ST_IDLE;
        endcase
    end

    assign run_en = (map_zone != ZN_OFF);

    // Output registers, loaded when leaving ST_SHAPE
    always_ff @(posedge clk) begin
        if (rst) begin
            dac_valid <= 1'b0;
            dac_code  <= '0;
            at_max_q  <= 1'b0;
        end else begin
            dac_valid <= (state_q == ST_SHAPE);
            if (state_q == ST_SHAPE) begin
                dac_code <= map_code;
                at_max_q <= map_at_max;
            end
        end
    end

    for (genvar g = 0; g < NPH; g++) begin : g_phase
        always_ff @(posedge clk) begin
            if (rst) begin
                phase_en[g] <= 1'b0;
            end else if (state_q == ST_SHAPE) begin
                phase_en[g] <= run_en;
            end
        end
    end

    AST_VALID_ONE: assert property (@(posedge clk) disable iff (rst)
        dac_valid |=> !dac_valid); // R1

    AST_QUIET_HOLD: assert property (@(posedge clk) disable iff (rst)
        !dac_valid |-> ($stable(dac_code) && $stable(phase_en))); // R10

    AST_CODE_LIVE: assert property (@(posedge clk) disable iff (rst)
        (dac_code != '0) |-> (phase_en == {NPH{1'b1}})); // R7

    AST_CODE_CEIL: assert property (@(posedge clk) disable iff (rst)
        (dac_valid && ($past(ref_min) <= $past(ref_max))) |-> (dac_code <= $past(ref_max))); // R5

    AST_OV_OFF: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_SHAPE && ov_q) |=> (phase_en == '0 && dac_code == '0)); // R8

    AST_PHASE_SAME: assert property (@(posedge clk) disable iff (rst)
        (phase_en == '0) || (phase_en == {NPH{1'b1}})); // R7

endmodule

// File: tb/tb_vloop_burst_ctrl.sv
module tb_vloop_burst_ctrl;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cyc_start = 1'b0;
    logic        adc_valid = 1'b0;
    logic [11:0] adc_data = '0;
    logic [11:0] vset = '0;
    logic [15:0] kp = '0;
    logic [15:0] ki = '0;
    logic [9:0]  ref_min = '0;
    logic [9:0]  ref_max = '0;
    logic [11:0] ov_margin = '0;
    logic        dac_valid;
    logic [9:0]  dac_code;
    logic [1:0]  phase_en;

    int nvec = 0;
    int nbad = 0;

    longint m_integ = 0;
    bit     m_atmax = 1'b0;

    always #4 clk = ~clk;

    vloop_burst_ctrl dut (
        .clk       (clk),
        .rst       (rst),
        .cyc_start (cyc_start),
        .adc_valid (adc_valid),
        .adc_data  (adc_data),
        .vset      (vset),
        .kp        (kp),
        .ki        (ki),
        .ref_min   (ref_min),
        .ref_max   (ref_max),
        .ov_margin (ov_margin),
        .dac_valid (dac_valid),
        .dac_code  (dac_code),
        .phase_en  (phase_en)
    );

    task automatic chk(string req, longint act, longint exp);
        nvec++;
        if (act != exp) begin
            nbad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Reference model of one evaluation
    task automatic model(int vs, int smp, int kpv, int kiv, int mn, int mx, int mg,
                         output int code, output int en);
        longint e, u, t, c;
        bit ov, hold;
        e    = longint'(vs) - longint'(smp);
        ov   = smp > (vs + mg);
        hold = m_atmax && (e > 0);
        if (!hold) begin
            t = m_integ + longint'(kiv) * e;
            if (t > 64'sd2147483647) t = 64'sd2147483647;
            if (t < -64'sd2147483648) t = -64'sd2147483648;
            m_integ = t;
        end
        u = (longint'(kpv) * e + m_integ + 128) >>> 8;
        m_atmax = (u >= mx);
        if (u < 0) c = 0; else if (u >= mx) c = mx; else c = u;
        if (ov) begin code = 0; en = 0; end
        else if (c >= mn) begin code = int'(c); en = 3; end
        else if (c >= (mn >> 1)) begin code = mn; en = 3; end
        else begin code = 0; en = 0; end
    endtask

    task automatic strobe();
        @(negedge clk) cyc_start = 1'b1;
        @(negedge clk) cyc_start = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk) rst = 1'b1;
        @(negedge clk);
        @(negedge clk) rst = 1'b0;
        m_integ = 0;
        m_atmax = 1'b0;
    endtask

    task automatic run_update(int vs, int smp, int kpv, int kiv, int mn, int mx, int mg, string req);
        int ec, ee;
        logic [9:0] held;
        @(negedge clk);
        vset = 12'(vs); kp = 16'(kpv); ki = 16'(kiv);
        ref_min = 10'(mn); ref_max = 10'(mx); ov_margin = 12'(mg);
        adc_valid = 1'b1; adc_data = 12'(smp);
        @(negedge clk);
        adc_valid = 1'b0; adc_data = 12'($urandom_range(0, 4095));
        for (int i = 0; i < 9; i++) strobe();
        chk("R1 no update before tenth strobe", dac_valid, 0);
        strobe();
        repeat (3) @(negedge clk);
        chk("R1 valid not early", dac_valid, 0);
        @(negedge clk);
        chk("R1 valid on fourth edge", dac_valid, 1);
        model(vs, smp, kpv, kiv, mn, mx, mg, ec, ee);
        chk({req, " dac_code"}, dac_code, ec);
        chk({req, " phase_en"}, phase_en, ee);
        held = dac_code;
        repeat (2) @(negedge clk);
        chk("R1 valid single pulse", dac_valid, 0);
        chk("R10 code held", dac_code, held);
    endtask

    initial begin
        int s, v;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R9 reset code", dac_code, 0);
        chk("R9 reset phases", phase_en, 0);
        chk("R9 reset valid", dac_valid, 0);

        // Zone corners with unity proportional gain and no integral action
        run_update(1500, 1000, 256, 0, 100, 800, 200, "R5 pass");
        run_update(1900, 1000, 256, 0, 100, 800, 2000, "R5 ceiling");
        run_update(1100, 1000, 256, 0, 100, 800, 200, "R5 at floor");
        run_update(1099, 1000, 256, 0, 100, 800, 200, "R6 below floor");
        run_update(1050, 1000, 256, 0, 100, 800, 200, "R6 half floor");
        run_update(1049, 1000, 256, 0, 100, 800, 200, "R7 below half");
        run_update(900, 1000, 256, 0, 100, 800, 200, "R7 negative");
        run_update(1003, 1000, 77, 0, 0, 800, 200, "R2 rounding");

        // Anti-windup hold at the ceiling
        do_reset();
        chk("R9 phases after reset", phase_en, 0);
        chk("R9 code after reset", dac_code, 0);
        for (int i = 0; i < 4; i++) run_update(1100, 1000, 0, 256, 20, 200, 100, "R4 run-up");
        run_update(990, 1000, 0, 256, 20, 200, 100, "R4 release");

        // Overvoltage boundary with a positive integrator
        do_reset();
        for (int i = 0; i < 3; i++) run_update(1300, 1000, 0, 256, 20, 1000, 10, "R2 build");
        run_update(1000, 1010, 0, 0, 20, 1000, 10, "R8 at margin");
        run_update(1000, 1011, 0, 0, 20, 1000, 10, "R8 above margin");

        // Negative saturation and recovery
        do_reset();
        for (int i = 0; i < 20; i++) run_update(0, 4095, 0, 32767, 0, 1023, 4095, "R3 sink");
        for (int i = 0; i < 20; i++) run_update(4095, 0, 0, 32767, 0, 1023, 4095, "R3 recover");

        // Constrained random
        do_reset();
        for (int i = 0; i < 120; i++) begin
            v = $urandom_range(400, 3600);
            s = v + $urandom_range(0, 600) - 300;
            run_update(v, s, $urandom_range(0, 1023), $urandom_range(0, 255),
                       $urandom_range(0, 200), $urandom_range(300, 1023),
                       $urandom_range(0, 250), "R2 random");
        end

        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        nbad++;
        $display("FAIL R1 watchdog expired actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end

endmodule